// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked requester and an external asynchronous static RAM of 1M words by 16 bits. The RAM has active-low chip, output, write and per-byte lane selects. The requester presents a word address, write data, a two-bit byte enable and a read/write flag, and holds the request until the controller answers with a one-cycle ready. The controller then plays out the memory's control sequence, with every phase length computed at elaboration from nanosecond timing parameters and the clock period.

A single write opens with a setup phase: the chip is selected, output enable is high and the address is stable. Write enable and the chosen lane selects then go low together for the pulse phase, with data driven. A recovery phase follows, in which the strobes rise and the data is held. A read selects the chip with output enable and the chosen lanes low for the access time, and registers the bus on the clock edge that ends it. When a write carries the burst flag, write enable stays low after it completes. The next burst word is then framed only by the lane selects, while output enable stays high the whole time. The tri-state data bus appears as separate output, output-enable and input vectors; the pad ring joins them.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, with no request, all five memory strobes are high (deasserted), the data bus driver is off and ready is low.
- R2: A single write takes SETUP+PULSE+REC clock cycles from acceptance to the ready cycle. Whenever chip select, write enable and at least one lane select are low at the same time, the bus is driven with the request's data.
- R3: A read holds chip select and output enable low for READ cycles and registers the bus on the edge that ends them. Ready and valid read data appear in the following cycle, READ+1 cycles after acceptance.
- R4: Byte enable bit 0 drives the lower lane select (data bits 7:0) and bit 1 the upper lane select (bits 15:8), both low for an enabled lane. On a write, a lane whose enable is 0 keeps its select high, so its stored byte is unchanged. A write with both enables 0 changes nothing.
- R5: In read data, any byte lane whose enable bit is 0 reads as zero, whatever the bus carries.
- R6: Output enable is high for the whole of every write. Before each falling edge of write enable it has been high for at least one full cycle.
- R7: The bus is never driven while output enable is low. Output enable only falls after a cycle in which chip select and write enable are high and the driver is off, so a write followed by a read always has an idle turnaround cycle.
- R8: After a write with the burst flag set, write enable stays low. A further burst write is accepted in the next cycle and goes straight to the pulse phase, taking 1+PULSE+REC cycles, with its write framed only by the lane selects. Any other request, or no request, raises write enable and returns to idle before a new request is accepted. A read that arrives in this state therefore completes READ+3 cycles after it is presented.
- R9: Ready is high for exactly one cycle per request. Requests are taken only in idle or in the burst hold state.
- R10: Each phase length is the nanosecond time divided by the clock period and rounded up, with a minimum of 1. SETUP comes from the output-enable-to-write time. PULSE is the largest of the write-pulse, data-setup and address-to-write-end times. REC is the write cycle length minus PULSE, at least 1. READ comes from the access time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid, held until ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | Keep write enable low after this write |
| req_addr_i | input | 20 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| ready_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Registered read data, lanes masked by enables |
| sram_addr_o | output | 20 | Memory address |
| sram_ce_no | output | 1 | Chip select, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_ub_no | output | 1 | Upper lane select, active low |
| sram_lb_no | output | 1 | Lower lane select, active low |
| sram_dq_o | output | 16 | Data bus output value |
| sram_dq_oe_o | output | 1 | Data bus driver enable |
| sram_dq_i | input | 16 | Data bus input value |

## Verification
The bench builds the controller with a 10 ns clock and the slow-grade timings: a 20 ns access, a 12 ns write pulse, 9 ns data setup, 12 ns address-to-write-end, a 20 ns write cycle and 4 ns from output enable to write. These give READ=2 and PULSE=2, so the multi-cycle pulse and access counters are exercised. The write cycle is no longer than the pulse, which exercises the one-cycle floor on recovery. A behavioural memory model with a floating-lane marker checks lane masking and partial writes against real stored state. Bus monitors watch contention, turnaround and write-enable activity across a three-word burst and a read issued straight after it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC,
    ST_BHOLD,
    ST_READ,
    ST_RDONE
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic ub_n;
    logic lb_n;
    logic dq_oe;
  } bus_ctrl_t;

  localparam bus_ctrl_t CTRL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned REC_CYC   = 1,
  parameter int unsigned READ_CYC  = 1,
  parameter int unsigned CW        = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       req_we_i,
  input  logic       req_burst_i,
  input  logic [1:0] req_be_i,
  output logic       accept_o,
  output logic       capture_o,
  output logic       ready_o,
  output bus_ctrl_t  ctrl_o
);

  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_PULSE = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] L_REC   = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] L_READ  = CW'(READ_CYC - 1);

  state_e        state_q, state_d;
  logic [1:0]    be_q, be_d;
  logic          burst_q, burst_d;
  logic          load, done;
  logic [CW-1:0] load_val;
  bus_ctrl_t     ctrl_q, ctrl_d;

  sram_ctrl_timer #(.CW(CW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    load     = 1'b0;
    load_val = L_SETUP;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load     = 1'b1;
        if (req_we_i) begin
          state_d  = ST_WSETUP;
          load_val = L_SETUP;
        end else begin
          state_d  = ST_READ;
          load_val = L_READ;
        end
      end
      ST_WSETUP: if (done) begin
        state_d = ST_WPULSE; load = 1'b1; load_val = L_PULSE;
      end
      ST_WPULSE: if (done) begin
        state_d = ST_WREC; load = 1'b1; load_val = L_REC;
      end
      ST_WREC: if (done) state_d = burst_q ? ST_BHOLD : ST_IDLE;
      ST_BHOLD: begin
        // only another burst write may reuse the low write enable
        if (req_i && req_we_i && req_burst_i) begin
          accept_o = 1'b1;
          state_d  = ST_WPULSE;
          load     = 1'b1;
          load_val = L_PULSE;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_READ:  if (done) state_d = ST_RDONE;
      ST_RDONE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign be_d    = accept_o ? req_be_i : be_q;
  assign burst_d = accept_o ? (req_we_i & req_burst_i) : burst_q;

  always_comb begin
    ctrl_d = CTRL_IDLE;
    unique case (state_d)
      ST_WSETUP: ctrl_d.ce_n = 1'b0;
      ST_WPULSE: begin
        ctrl_d.ce_n  = 1'b0;
        ctrl_d.we_n  = 1'b0;
        ctrl_d.ub_n  = ~be_d[1];
        ctrl_d.lb_n  = ~be_d[0];
        ctrl_d.dq_oe = 1'b1;
      end
      ST_WREC: begin
        ctrl_d.ce_n  = 1'b0;
        ctrl_d.we_n  = ~burst_d;
        ctrl_d.dq_oe = 1'b1;   // data hold past the ending edge
      end
      ST_BHOLD: begin
        ctrl_d.ce_n = 1'b0;
        ctrl_d.we_n = 1'b0;
      end
      ST_READ: begin
        ctrl_d.ce_n = 1'b0;
        ctrl_d.oe_n = 1'b0;
        ctrl_d.ub_n = ~be_d[1];
        ctrl_d.lb_n = ~be_d[0];
      end
      default: ctrl_d = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      be_q    <= '0;
      burst_q <= 1'b0;
      ctrl_q  <= CTRL_IDLE;
    end else begin
      state_q <= state_d;
      be_q    <= be_d;
      burst_q <= burst_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign capture_o = (state_q == ST_READ) && done;
  assign ready_o   = ((state_q == ST_WREC) && done) || (state_q == ST_RDONE);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R9
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.oe_n |-> !ctrl_q.dq_oe); // R7
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.oe_n) |-> $past(ctrl_q.ce_n && ctrl_q.we_n && !ctrl_q.dq_oe)); // R7
  AST_OE_HIGH_AT_WE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.we_n) |-> (ctrl_q.oe_n && $past(ctrl_q.oe_n))); // R6
  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.ce_n && !ctrl_q.we_n && !(ctrl_q.ub_n && ctrl_q.lb_n)) |-> ctrl_q.dq_oe); // R2
  AST_BURST_HOLDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BHOLD) |-> !ctrl_q.we_n); // R8

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            capture_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]   sram_dq_i,
  output logic [AW-1:0]   sram_addr_o,
  output logic [DW-1:0]   sram_dq_o,
  output logic [DW-1:0]   rdata_o
);

  localparam int unsigned LANES = DW / 8;

  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        byte_q <= '0;
      else if (capture_i) byte_q <= be_q[g] ? sram_dq_i[g*8 +: 8] : 8'h00;
    end
    assign rdata_o[g*8 +: 8] = byte_q;

    AST_LANE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (capture_i && !be_q[g]) |=> (rdata_o[g*8 +: 8] == 8'h00)); // R5
  end

  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW             = 20,
  parameter int unsigned DW             = 16,
  parameter int unsigned CLK_PERIOD_NS  = 10,
  parameter int unsigned T_ACCESS_NS    = 10,
  parameter int unsigned T_WPULSE_NS    = 8,
  parameter int unsigned T_DSETUP_NS    = 6,
  parameter int unsigned T_ADDR_WEND_NS = 8,
  parameter int unsigned T_WCYCLE_NS    = 10,
  parameter int unsigned T_OE_WE_NS     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_burst_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_be_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic          sram_ub_no,
  output logic          sram_lb_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int unsigned SETUP_CYC = ns2cyc(T_OE_WE_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = max2(ns2cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                      max2(ns2cyc(T_DSETUP_NS, CLK_PERIOD_NS),
                                           ns2cyc(T_ADDR_WEND_NS, CLK_PERIOD_NS)));
  localparam int unsigned WC_CYC    = ns2cyc(T_WCYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC   = (WC_CYC > PULSE_CYC) ? WC_CYC - PULSE_CYC : 1;
  localparam int unsigned READ_CYC  = ns2cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(REC_CYC, READ_CYC));
  localparam int unsigned CW        = (MAX_CYC <= 2) ? 1 : $clog2(MAX_CYC);

  logic      accept, capture;
  bus_ctrl_t ctrl;

  sram_ctrl_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC),
    .READ_CYC  (READ_CYC),
    .CW        (CW)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_burst_i (req_burst_i),
    .req_be_i    (req_be_i),
    .accept_o    (accept),
    .capture_o   (capture),
    .ready_o     (ready_o),
    .ctrl_o      (ctrl)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .be_i        (req_be_i),
    .sram_dq_i   (sram_dq_i),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .rdata_o     (rdata_o)
  );

  assign sram_ce_no   = ctrl.ce_n;
  assign sram_oe_no   = ctrl.oe_n;
  assign sram_we_no   = ctrl.we_n;
  assign sram_ub_no   = ctrl.ub_n;
  assign sram_lb_no   = ctrl.lb_n;
  assign sram_dq_oe_o = ctrl.dq_oe;

  AST_ADDR_STABLE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && !$past(sram_we_no) && !(sram_ub_no && sram_lb_no)
     && !$past(sram_ub_no && sram_lb_no)) |-> $stable(sram_addr_o)); // R2

endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

  localparam int CLK = 10;
  localparam int T_RD = 20, T_PW = 12, T_SD = 9, T_AW = 12, T_WC = 20, T_OEW = 4;

  // phase lengths computed here from R10
  localparam int B_SETUP = ((T_OEW + CLK - 1) / CLK) < 1 ? 1 : (T_OEW + CLK - 1) / CLK;
  localparam int B_PW    = (T_PW + CLK - 1) / CLK;
  localparam int B_SD    = (T_SD + CLK - 1) / CLK;
  localparam int B_AWC   = (T_AW + CLK - 1) / CLK;
  localparam int B_PULSE = (B_PW > B_SD) ? ((B_PW > B_AWC) ? B_PW : B_AWC)
                                         : ((B_SD > B_AWC) ? B_SD : B_AWC);
  localparam int B_WC    = (T_WC + CLK - 1) / CLK;
  localparam int B_REC   = (B_WC > B_PULSE) ? B_WC - B_PULSE : 1;
  localparam int B_READ  = (T_RD + CLK - 1) / CLK;
  localparam int LAT_WR  = B_SETUP + B_PULSE + B_REC;
  localparam int LAT_RD  = B_READ + 1;
  localparam int LAT_BW  = 1 + B_PULSE + B_REC;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0, req_burst = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        ready;
  logic [15:0] rdata, dq_o, dq_i;
  logic [19:0] maddr;
  logic        ce_n, oe_n, we_n, ub_n, lb_n, dq_oe;

  int checks = 0, failures = 0;

  always #(CLK/2) clk = ~clk;

  sram_ctrl #(
    .CLK_PERIOD_NS(CLK), .T_ACCESS_NS(T_RD), .T_WPULSE_NS(T_PW), .T_DSETUP_NS(T_SD),
    .T_ADDR_WEND_NS(T_AW), .T_WCYCLE_NS(T_WC), .T_OE_WE_NS(T_OEW)
  ) i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we), .req_burst_i(req_burst),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .ready_o(ready), .rdata_o(rdata), .sram_addr_o(maddr),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_ub_no(ub_n), .sram_lb_no(lb_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // memory model: 256 words with address tags, floating lanes read A5
  logic [15:0] mem [256];
  logic [11:0] tag [256];
  initial for (int i = 0; i < 256; i++) begin mem[i] = 16'h0000; tag[i] = 12'hFFF; end

  always_comb begin
    logic [15:0] w;
    w = (tag[maddr[7:0]] == maddr[19:8]) ? mem[maddr[7:0]] : 16'h0BAD;
    dq_i = 16'hA5A5;
    if (!ce_n && !oe_n && we_n) begin
      if (!lb_n) dq_i[7:0]  = w[7:0];
      if (!ub_n) dq_i[15:8] = w[15:8];
    end
  end

  int v_drive = 0, v_turn = 0, v_oewe = 0, v_ready = 0, v_nodata = 0;
  int we_rise = 0, lb_fall = 0;
  logic p_ce = 1, p_oe = 1, p_we = 1, p_lb = 1, p_oe_dq = 0, p_ready = 0;

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !we_n && !(ub_n && lb_n)) begin
      if (!dq_oe) v_nodata++;
      if (!lb_n) mem[maddr[7:0]][7:0]  <= dq_o[7:0];
      if (!ub_n) mem[maddr[7:0]][15:8] <= dq_o[15:8];
      tag[maddr[7:0]] <= maddr[19:8];
    end
    if (dq_oe && !oe_n) v_drive++;
    if (p_oe && !oe_n && !(p_ce && p_we && !p_oe_dq)) v_turn++;
    if (p_we && !we_n && !(p_oe && oe_n)) v_oewe++;
    if (ready && p_ready) v_ready++;
    if (!p_we && we_n) we_rise++;
    if (p_lb && !lb_n) lb_fall++;
    p_ce = ce_n; p_oe = oe_n; p_we = we_n; p_lb = lb_n; p_oe_dq = dq_oe; p_ready = ready;
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic b, input logic [1:0] be,
                       input logic [19:0] a, input logic [15:0] d);
    req = 1'b1; req_we = w; req_burst = b; req_be = be; req_addr = a; req_wdata = d;
  endtask

  task automatic wait_ready(output int lat, output logic [15:0] rd);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready && lat < 64);
    rd = rdata;
    if (lat >= 64) chk(1'b0, "R9 ready timeout", 32'(lat), 32'd0);
  endtask

  // {we, burst, be[1:0], addr[19:0], data[15:0]}; read data field = expected
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b11, 20'h12301, 16'hBEEF},
    {1'b1, 1'b0, 2'b11, 20'hFFF02, 16'h1234},
    {1'b0, 1'b0, 2'b11, 20'h12301, 16'hBEEF},
    {1'b0, 1'b0, 2'b11, 20'hFFF02, 16'h1234},
    {1'b1, 1'b0, 2'b01, 20'h12301, 16'h55AA},
    {1'b0, 1'b0, 2'b11, 20'h12301, 16'hBEAA},
    {1'b1, 1'b0, 2'b10, 20'h12301, 16'h77CC},
    {1'b0, 1'b0, 2'b11, 20'h12301, 16'h77AA},
    {1'b0, 1'b0, 2'b01, 20'h12301, 16'h00AA},
    {1'b0, 1'b0, 2'b10, 20'h12301, 16'h7700},
    {1'b1, 1'b0, 2'b00, 20'hFFF02, 16'hFFFF},
    {1'b0, 1'b0, 2'b11, 20'hFFF02, 16'h1234}
  };

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] rd;

    repeat (3) @(negedge clk);
    chk({ce_n, oe_n, we_n, ub_n, lb_n} == 5'h1F && !dq_oe && !ready, "R1 strobes in reset",
        {26'd0, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe}, 32'h3E);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ce_n, oe_n, we_n, ub_n, lb_n} == 5'h1F && !dq_oe && !ready, "R1 idle after reset",
        {26'd0, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe}, 32'h3E);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][39], VEC[i][38], VEC[i][37:36], VEC[i][35:16], VEC[i][15:0]);
      wait_ready(lat, rd);
      req = 1'b0;
      if (VEC[i][39]) begin
        chk(lat == LAT_WR, "R2 R10 write latency", 32'(lat), 32'(LAT_WR));
      end else begin
        chk(lat == LAT_RD, "R3 R10 read latency", 32'(lat), 32'(LAT_RD));
        // R4 R5: lane writes and masked reads
        chk(rd == VEC[i][15:0], "R3 R4 R5 read data", {16'd0, rd}, {16'd0, VEC[i][15:0]});
      end
      @(negedge clk);
      chk(!ready, "R9 ready single cycle", {31'd0, ready}, 32'd0);
    end

    // R8 burst of three words, then a read presented in the hold state
    @(negedge clk);
    we_rise = 0; lb_fall = 0;
    drive(1'b1, 1'b1, 2'b11, 20'h40010, 16'hA001);
    wait_ready(lat, rd);
    chk(lat == LAT_WR, "R8 first burst word latency", 32'(lat), 32'(LAT_WR));
    drive(1'b1, 1'b1, 2'b11, 20'h40011, 16'hA002);
    wait_ready(lat, rd);
    chk(lat == LAT_BW, "R8 chained burst word latency", 32'(lat), 32'(LAT_BW));
    drive(1'b1, 1'b1, 2'b11, 20'h40012, 16'hA003);
    wait_ready(lat, rd);
    chk(lat == LAT_BW, "R8 last burst word latency", 32'(lat), 32'(LAT_BW));
    chk(we_rise == 0, "R8 write enable held low in burst", 32'(we_rise), 32'd0);
    chk(lb_fall == 3, "R8 lane strobe per word", 32'(lb_fall), 32'd3);
    drive(1'b0, 1'b0, 2'b11, 20'h40012, 16'h0000);
    wait_ready(lat, rd);
    req = 1'b0;
    chk(lat == B_READ + 3, "R8 read after burst latency", 32'(lat), 32'(B_READ + 3));
    chk(rd == 16'hA003, "R8 read after burst data", {16'd0, rd}, 32'hA003);
    chk(we_rise == 1, "R8 write enable released", 32'(we_rise), 32'd1);

    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      drive(1'b0, 1'b0, 2'b11, 20'h40010 + 20'(i), 16'h0000);
      wait_ready(lat, rd);
      req = 1'b0;
      chk(rd == 16'hA001 + 16'(i), "R8 burst word stored", {16'd0, rd}, 32'hA001 + 32'(i));
    end

    repeat (3) @(negedge clk);
    chk({ce_n, oe_n, we_n, ub_n, lb_n} == 5'h1F && !dq_oe, "R1 idle strobes at end",
        {26'd0, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe}, 32'h3E);
    chk(v_drive == 0, "R7 bus driven with OE low", 32'(v_drive), 32'd0);
    chk(v_turn == 0, "R7 turnaround cycle missing", 32'(v_turn), 32'd0);
    chk(v_oewe == 0, "R6 OE not high before WE fall", 32'(v_oewe), 32'd0);
    chk(v_ready == 0, "R9 ready longer than one cycle", 32'(v_ready), 32'd0);
    chk(v_nodata == 0, "R2 write overlap without data", 32'(v_nodata), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule